// File: doc/BRIEF.md
# Dual-Phase Latched PWM Controller

This block is a synchronous pulse-width controller for push-pull power stages. A period counter produces a digital sawtooth of programmable length. A programmable clock (deadtime) interval follows it. During that interval both outputs are held low. The two outputs, `out_a` and `out_b`, take turns: each switching period drives only one of them. Each output can therefore fire at most once every two periods.

Within a period, the active output rises when the ramp starts. It falls when the ramp reaches the compare threshold. The threshold is the smaller of the duty command (captured at the start of the period) and a soft-start level. A set-dominant latch ends the pulse and holds it off until the next clock interval.

A shutdown input acts on two time scales. A brief pulse kills only the current pulse, which allows pulse-by-pulse limiting. A shutdown held across period boundaries drains the soft-start level, so the outputs ramp up slowly again after release. An undervoltage flag blocks both outputs and freezes the soft-start level. An external sync pulse forces the clock interval at once, so several controllers can share one period.

Top module: `dual_phase_pwm`

## Requirements
- R1: Only one output can be driven per period. The outputs swap from one period to the next, and `out_a` and `out_b` are never high together. The period that starts when reset is released drives neither output. The period after it belongs to `out_b`.
- R2: The ramp part of a period lasts `ramp_len` cycles, with counter values 0 to `ramp_len`-1. It is followed by a clock interval of `dead_len` cycles, during which `clk_pulse` is high. A length of 0 is treated as 1.
- R3: Both outputs are low in every cycle in which `clk_pulse` is high.
- R4: The active output is high from the first ramp cycle for exactly min(threshold, `ramp_len`) cycles, where threshold = min(captured duty, soft-start level). Once it falls, it stays low until the next clock interval.
- R5: `duty_cmd` is captured only in the last cycle of the clock interval. A change in the middle of a ramp has no effect on the period in progress.
- R6: A threshold of 0 gives no pulse at all.
- R7: A high `shdn` forces both outputs low in the same cycle. It keeps the active output low for the rest of that period, even after `shdn` falls.
- R8: At each period boundary where `shdn` is high, the soft-start level falls by 2^CW/DRAIN_PERIODS, saturating at 0. DRAIN_PERIODS such boundaries in a row bring it to 0. A `shdn` pulse that is low at the boundary leaves the level unchanged.
- R9: The soft-start level is 0 after reset. It rises by SS_INC, saturating at 2^CW-1, once every `ss_div` period boundaries (0 is treated as 1). It never changes between boundaries.
- R10: While `uv_flag` is high, both outputs are low and the soft-start level does not rise.
- R11: A high `sync_in` during a ramp cycle ends the ramp: the next cycle is the first cycle of a full clock interval.
- R12: `rst_n` is asynchronous and active low, and its release is synchronised. While it is asserted, both outputs and `clk_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | CW | Duty command in ramp counts |
| ramp_len | input | CW | Ramp length in cycles |
| dead_len | input | DW | Clock (deadtime) interval length in cycles |
| ss_div | input | SW | Periods per soft-start rise step |
| shdn | input | 1 | Shutdown; kills the pulse and drains soft-start while held |
| uv_flag | input | 1 | Undervoltage; blocks outputs and freezes soft-start |
| sync_in | input | 1 | External sync; starts a clock interval |
| out_a | output | 1 | Phase A drive, low when off |
| out_b | output | 1 | Phase B drive, low when off |
| clk_pulse | output | 1 | High during the clock interval |

## Verification
The assertions assume that `shdn`, `uv_flag` and `sync_in` are already synchronous to `clk`. They also assume that `ramp_len`, `dead_len` and `ss_div` stay constant while a test runs. The bench therefore changes every input only on the falling clock edge. It sets the lengths once before reset and never changes them afterwards. `sync_in` is raised for a single cycle, and only inside a ramp. `duty_cmd`, `shdn` and `uv_flag` are changed either during a clock interval or at a known ramp count. This makes the sampled period exact.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [CW-1:0] ramp_len,
  input  logic [DW-1:0] dead_len,
  input  logic          sync_in,
  output logic [CW-1:0] cnt_o,
  output logic          in_dead_o,
  output logic          period_end_o
);
  localparam int CWX = CW + 1;
  localparam int DWX = DW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          dead_q, dead_d;
  logic          ramp_end, dead_end;

  // last-cycle detection; zero lengths collapse to one cycle
  assign ramp_end = (CWX'(cnt_q) + CWX'(1)) >= CWX'(ramp_len);
  assign dead_end = (DWX'(dcnt_q) + DWX'(1)) >= DWX'(dead_len);

  always_comb begin
    cnt_d  = cnt_q;
    dcnt_d = dcnt_q;
    dead_d = dead_q;
    if (sync_in) begin
      dead_d = 1'b1;
      dcnt_d = '0;
    end else if (dead_q) begin
      if (dead_end) begin
        dead_d = 1'b0;
        cnt_d  = '0;
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end else if (ramp_end) begin
      dead_d = 1'b1;
      dcnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dcnt_q <= '0;
      dead_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dcnt_q <= dcnt_d;
      dead_q <= dead_d;
    end
  end

  assign cnt_o        = cnt_q;
  assign in_dead_o    = dead_q;
  assign period_end_o = dead_q & dead_end & ~sync_in;

  // R11: a sync request always opens a clock interval next cycle
  p_sync_dead_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    sync_in |=> (in_dead_o && dcnt_q == '0));
  // R2: the ramp counter only moves while the ramp is running
  p_ramp_frozen_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (dead_q && !sync_in && !dead_end) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
  parameter int CW            = 8,
  parameter int SW            = 4,
  parameter int SS_INC        = 16,
  parameter int DRAIN_PERIODS = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          period_end,
  input  logic          shdn,
  input  logic          uv,
  input  logic [SW-1:0] ss_div,
  output logic [CW-1:0] ss_lvl
);
  localparam int CWX       = CW + 1;
  localparam int SWX       = SW + 1;
  localparam int DRAIN_RAW = (1 << CW) / DRAIN_PERIODS;
  localparam int DRAIN     = (DRAIN_RAW < 1) ? 1 : DRAIN_RAW;
  localparam logic [CWX-1:0] STEP_DN = CWX'(DRAIN);
  localparam logic [CWX-1:0] STEP_UP = CWX'(SS_INC);
  localparam logic [CWX-1:0] LVL_MAX = CWX'((1 << CW) - 1);

  logic [CW-1:0]  lvl_q, lvl_d;
  logic [SW-1:0]  div_q, div_d;
  logic [CWX-1:0] up_sum;
  logic           div_hit;

  assign up_sum  = CWX'(lvl_q) + STEP_UP;
  assign div_hit = (SWX'(div_q) + SWX'(1)) >= SWX'(ss_div);

  always_comb begin
    lvl_d = lvl_q;
    div_d = div_q;
    if (period_end) begin
      if (shdn) begin
        div_d = '0;
        lvl_d = (CWX'(lvl_q) < STEP_DN) ? '0 : CW'(CWX'(lvl_q) - STEP_DN);
      end else if (!uv) begin
        if (div_hit) begin
          div_d = '0;
          lvl_d = (up_sum > LVL_MAX) ? CW'(LVL_MAX) : CW'(up_sum);
        end else begin
          div_d = div_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      div_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      div_q <= div_d;
    end
  end

  assign ss_lvl = lvl_q;

  // R9: level changes only at a period boundary
  p_ss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !period_end |=> $stable(ss_lvl));
  // R8: a boundary seen under shutdown never raises the level
  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (period_end && shdn) |=> ss_lvl <= $past(ss_lvl));
  // R10: undervoltage freezes the level
  p_uv_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (period_end && uv && !shdn) |=> $stable(ss_lvl));
endmodule

// File: rtl/pwm_latch_out.sv
module pwm_latch_out
  import pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          in_dead,
  input  logic          period_end,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] thr,
  input  logic          shdn,
  input  logic          uv,
  output logic          out_a,
  output logic          out_b
);
  logic   latch_q, latch_d;
  phase_e phase_q, phase_d;
  logic   cmp_hit, kill;

  assign cmp_hit = ~in_dead & (cnt >= thr);

  // set wins over the clock-interval reset
  always_comb begin
    latch_d = latch_q;
    if (shdn || cmp_hit)
      latch_d = 1'b1;
    else if (in_dead)
      latch_d = 1'b0;
    phase_d = period_end ? ((phase_q == PH_A) ? PH_B : PH_A) : phase_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b1;
      phase_q <= PH_A;
    end else begin
      latch_q <= latch_d;
      phase_q <= phase_d;
    end
  end

  // NOR combination: any off cause pulls the output low
  assign kill  = in_dead | latch_q | shdn | cmp_hit | uv;
  assign out_a = ~(kill | (phase_q != PH_A));
  assign out_b = ~(kill | (phase_q != PH_B));

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !(out_a && out_b));
  p_dead_quiet_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    in_dead |-> !(out_a || out_b));
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (latch_q && !in_dead) |=> latch_q);
  p_shdn_kill_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    shdn |-> !(out_a || out_b));
  p_uv_block_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    uv |-> !(out_a || out_b));
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm #(
  parameter int CW            = 8,
  parameter int DW            = 4,
  parameter int SW            = 4,
  parameter int SS_INC        = 16,
  parameter int DRAIN_PERIODS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_cmd,
  input  logic [CW-1:0] ramp_len,
  input  logic [DW-1:0] dead_len,
  input  logic [SW-1:0] ss_div,
  input  logic          shdn,
  input  logic          uv_flag,
  input  logic          sync_in,
  output logic          out_a,
  output logic          out_b,
  output logic          clk_pulse
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [CW-1:0] cnt, ss_lvl, thr;
  logic [CW-1:0] duty_q, duty_d;
  logic          in_dead, period_end;

  // asynchronous assertion, synchronised release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pwm_timebase #(.CW(CW), .DW(DW)) u_tb (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .ramp_len     (ramp_len),
    .dead_len     (dead_len),
    .sync_in      (sync_in),
    .cnt_o        (cnt),
    .in_dead_o    (in_dead),
    .period_end_o (period_end)
  );

  pwm_softstart #(.CW(CW), .SW(SW), .SS_INC(SS_INC),
                  .DRAIN_PERIODS(DRAIN_PERIODS)) u_ss (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .period_end (period_end),
    .shdn       (shdn),
    .uv         (uv_flag),
    .ss_div     (ss_div),
    .ss_lvl     (ss_lvl)
  );

  // duty command held for a whole period
  assign duty_d = period_end ? duty_cmd : duty_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) duty_q <= '0;
    else         duty_q <= duty_d;
  end

  assign thr = (duty_q < ss_lvl) ? duty_q : ss_lvl;

  pwm_latch_out #(.CW(CW)) u_lo (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .in_dead    (in_dead),
    .period_end (period_end),
    .cnt        (cnt),
    .thr        (thr),
    .shdn       (shdn),
    .uv         (uv_flag),
    .out_a      (out_a),
    .out_b      (out_b)
  );

  assign clk_pulse = in_dead;

  // R5: captured duty moves only on a period boundary
  p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !period_end |=> $stable(duty_q));
endmodule

// File: tb/sim_dual_phase_pwm.sv
module sim_dual_phase_pwm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] duty_cmd, ramp_len;
  logic [3:0] dead_len, ss_div;
  logic       shdn, uv_flag, sync_in;
  logic       out_a, out_b, clk_pulse;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int g_wa, g_wb, g_nr, g_dc;
  bit g_dead_bad;
  bit expb;

  always #2.5 clk = ~clk;

  dual_phase_pwm u0 (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .ramp_len(ramp_len),
    .dead_len(dead_len), .ss_div(ss_div), .shdn(shdn), .uv_flag(uv_flag),
    .sync_in(sync_in), .out_a(out_a), .out_b(out_b), .clk_pulse(clk_pulse)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++;
      total++;
      $display("FAIL R12 watchdog: cycles=%0d expected below=%0d", cyc, 60000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 new duty at idx, 2 shdn for val cycles, 3 one-cycle sync
  task automatic run_period(input int act_at, input int kind, input int val);
    int idx;
    while (!clk_pulse) @(negedge clk);
    g_dc = 0;
    g_dead_bad = 1'b0;
    while (clk_pulse) begin
      if (out_a || out_b) g_dead_bad = 1'b1;
      g_dc++;
      @(negedge clk);
    end
    g_wa = 0; g_wb = 0; idx = 0;
    while (!clk_pulse) begin
      if (out_a) g_wa++;
      if (out_b) g_wb++;
      if (out_a && out_b) g_dead_bad = 1'b1;
      if (idx == act_at) begin
        if (kind == 1) duty_cmd = 8'(val);
        if (kind == 2) shdn = 1'b1;
        if (kind == 3) sync_in = 1'b1;
      end
      if (kind == 2 && idx == act_at + val) shdn = 1'b0;
      @(negedge clk);
      if (kind == 3) sync_in = 1'b0;
      idx++;
    end
    g_nr = idx;
  endtask

  task automatic exp_period(input int w, input string tag);
    int act, oth;
    act = expb ? g_wb : g_wa;
    oth = expb ? g_wa : g_wb;
    chk(act == w, {tag, " active width"}, act, w);
    chk(oth == 0, "R1 idle phase width", oth, 0);
    chk(!g_dead_bad, "R3 outputs during clock interval", int'(g_dead_bad), 0);
    expb = ~expb;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_a && !out_b, "R12 outputs in reset", int'(out_a | out_b), 0);
    chk(!clk_pulse, "R12 clk_pulse in reset", int'(clk_pulse), 0);
    rst_n = 1'b1;
    expb = 1'b1;
  endtask

  task automatic t_softstart();
    for (int k = 1; k <= 5; k++) begin
      run_period(-1, 0, 0);
      chk(g_dc == 3, "R2 clock interval length", g_dc, 3);
      chk(g_nr == 64, "R2 ramp length", g_nr, 64);
      exp_period((16 * k < 64) ? 16 * k : 64, "R9 soft-start R4");
    end
  endtask

  task automatic t_sample();
    run_period(10, 1, 5);
    exp_period(64, "R5 mid-ramp duty ignored");
    run_period(-1, 0, 0);
    exp_period(5, "R5 duty captured R4");
  endtask

  task automatic t_zero();
    duty_cmd = 8'd0;
    run_period(-1, 0, 0);
    exp_period(0, "R6 zero duty");
    run_period(-1, 0, 0);
    exp_period(0, "R6 zero duty");
  endtask

  task automatic t_short_shdn();
    duty_cmd = 8'd30;
    run_period(-1, 0, 0);
    exp_period(30, "R4 duty below ramp");
    run_period(10, 2, 2);
    exp_period(11, "R7 shutdown kill");
    run_period(-1, 0, 0);
    exp_period(30, "R8 short shutdown keeps level");
  endtask

  task automatic t_long_shdn();
    shdn = 1'b1;
    for (int k = 0; k < 9; k++) begin
      run_period(-1, 0, 0);
      exp_period(0, "R8 held shutdown");
    end
    shdn = 1'b0;
    run_period(-1, 0, 0);
    exp_period(16, "R8 drained to zero");
    run_period(-1, 0, 0);
    exp_period(30, "R9 rise after drain");
  endtask

  task automatic t_uv();
    shdn = 1'b1;
    for (int k = 0; k < 9; k++) begin
      run_period(-1, 0, 0);
      expb = ~expb;
    end
    uv_flag = 1'b1;
    shdn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      run_period(-1, 0, 0);
      exp_period(0, "R10 undervoltage block");
    end
    uv_flag = 1'b0;
    run_period(-1, 0, 0);
    exp_period(16, "R10 level frozen");
    run_period(-1, 0, 0);
    exp_period(30, "R10 recovery");
  endtask

  task automatic t_sync();
    run_period(20, 3, 0);
    chk(g_nr == 21, "R11 sync ends ramp", g_nr, 21);
    exp_period(21, "R11 sync cut width");
    run_period(-1, 0, 0);
    chk(g_dc == 3, "R11 full interval after sync", g_dc, 3);
    chk(g_nr == 64, "R11 next ramp full", g_nr, 64);
    exp_period(30, "R11 width after sync");
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    while (clk_pulse) @(negedge clk);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!out_a && !out_b && !clk_pulse, "R12 asynchronous reset",
        int'(out_a | out_b | clk_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    expb = 1'b1;
    run_period(-1, 0, 0);
    exp_period(16, "R12 soft-start cleared R1");
  endtask

  initial begin
    duty_cmd = 8'd255;
    ramp_len = 8'd64;
    dead_len = 4'd3;
    ss_div   = 4'd1;
    shdn     = 1'b0;
    uv_flag  = 1'b0;
    sync_in  = 1'b0;
    expb     = 1'b1;
    @(negedge clk);
    t_reset();
    t_softstart();
    t_sample();
    t_zero();
    t_short_shdn();
    t_long_shdn();
    t_uv();
    t_sync();
    t_reset_again();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule